// File: doc/BRIEF.md
# Card Status-Change Event Register Block

This block holds the event and mask registers that a bus-attached network function uses to report wake-up and interrupt conditions to its host. Two sticky event flags are kept. One is a wake flag fed by a present-state wake level. The other is an interrupt flag fed by the function's internal interrupt-pending level. The host reads both flags and clears them by writing ones. A separate mask register decides which conditions drive the active-low status-change line and the active-low interrupt line.

The status-change line also carries three external card conditions: write-protect, ready/busy and battery-voltage. All of them are gated by a global wake enable in the mask register. The wake flag needs its own enable bit as well. Writing a one to clear the wake flag also sends a one-cycle pulse that clears the power-management status flag held elsewhere. A mode-enable input switches the whole block on or off.

Top module: `cstat_evt_top`

## Requirements
- R1: After reset the event register (offset 0x24) and the mask register (offset 0x28) both read 0x00000000, `statChgN` and `intN` are high and `pmeClr` is low.
- R2: Reads at offset 0x24 return the event register and reads at offset 0x28 return the mask register. Any other offset reads 0, and writes to any other offset change neither register. Mask bits 4 (wake enable), 14 (global wake enable) and 15 (interrupt enable) are writable and read back what was written.
- R3: While the block is enabled and `wakePresent` is 1 at a clock edge, event bit 4 is 1 after that edge. It stays 1 for as long as `wakePresent` stays 1, even when a write-1 clear arrives in the same cycle (set wins). It stays 1 after `wakePresent` falls.
- R4: A write of 1 to event bit 4 while `wakePresent` is 0 clears that bit at the write edge. Any write of 1 to event bit 4 while enabled drives `pmeClr` high for exactly the one cycle after the write edge. Writing 0 to an event bit leaves it unchanged.
- R5: Event bit 15 is set at the edge where `intPending` is 1, whatever the value of mask bit 15. It stays set until a write of 1 to bit 15 is made while `intPending` is 0.
- R6: `intN` is low exactly when the block is enabled, mask bit 15 is 1 and event bit 15 is 1. It follows the register contents in the same cycle.
- R7: `statChgN` is low exactly when the block is enabled, mask bit 14 is 1, and at least one of the following holds: `wpEvt`, `rdyEvt`, `battEvt`, or (mask bit 4 and event bit 4).
- R8: Reserved bits read as 0 and ignore written ones. In the event register these are 31..16, 14..5 and 3..0. In the mask register they are 31..16, 13..5 and 3..0.
- R9: While `modeEn` is 0, reads return 0, writes are ignored, `pmeClr` stays low, both active-low outputs are high, and both registers keep their contents. The event sources are not latched during this time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeEn | input | 1 | Block enable; 0 disables all register access and outputs |
| wrEn | input | 1 | Register write strobe for the current cycle |
| addr | input | ADDR_W | Byte offset of the register access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| wakePresent | input | 1 | Present-state wake level |
| intPending | input | 1 | Internal interrupt-pending level |
| wpEvt | input | 1 | Write-protect change condition |
| rdyEvt | input | 1 | Ready/busy change condition |
| battEvt | input | 1 | Battery-voltage change condition |
| statChgN | output | 1 | Active-low status-change output |
| intN | output | 1 | Active-low interrupt output |
| pmeClr | output | 1 | One-cycle pulse that clears the power-management status flag |

## Verification
Register writes and source levels take effect at the clock edge where they are sampled. The new register value is therefore visible on `rdData`, `intN` and `statChgN` from the next falling edge onward. `pmeClr` is registered, so it is high during the single cycle after the write edge and low again one cycle later. The condition inputs and `modeEn` act on `statChgN`, `intN` and `rdData` with no register between them, so these outputs are checked one time step after the inputs change. The bench drives every input on the falling edge and samples either just after that edge or at the next falling edge, never at a rising edge.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
  localparam int DATA_W    = 32;
  localparam int WAKE_BIT  = 4;
  localparam int GWAKE_BIT = 14;
  localparam int INTR_BIT  = 15;
  localparam int NUM_STICKY = 2;

  localparam logic [DATA_W-1:0] MASK_IMPL =
    (DATA_W'(1) << WAKE_BIT) | (DATA_W'(1) << GWAKE_BIT) | (DATA_W'(1) << INTR_BIT);

  typedef struct packed {
    logic enable;
    logic wrEvt;
    logic wrMask;
    logic rdEvt;
    logic rdMask;
  } ctlStrb_t;
endpackage

// File: rtl/cstat_sticky_bit.sv
module cstat_sticky_bit (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic setReq,
  input  logic clrReq,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rstN) q <= 1'b0;
    else if (enable) begin
      if (setReq)      q <= 1'b1;
      else if (clrReq) q <= 1'b0;
    end
  end
endmodule

// File: rtl/cstat_evt_ctrl.sv
module cstat_evt_ctrl
  import cstat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] EVT_OFS  = 'h24,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrWakeBit,
  output ctlStrb_t          strb,
  output logic              pmeClr
);
  logic hitEvt, hitMask;

  always_comb begin
    hitEvt      = (addr == EVT_OFS);
    hitMask     = (addr == MASK_OFS);
    strb.enable = modeEn;
    strb.wrEvt  = modeEn & wrEn & hitEvt;
    strb.wrMask = modeEn & wrEn & hitMask;
    strb.rdEvt  = modeEn & hitEvt;
    strb.rdMask = modeEn & hitMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pmeClr <= 1'b0;
    else       pmeClr <= strb.wrEvt & wrWakeBit;
  end
endmodule

// File: rtl/cstat_evt_dp.sv
module cstat_evt_dp
  import cstat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wakePresent,
  input  logic              intPending,
  input  logic              wpEvt,
  input  logic              rdyEvt,
  input  logic              battEvt,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] evtQ,
  output logic [DATA_W-1:0] maskQ,
  output logic              statChgN,
  output logic              intN
);
  localparam int STICKY_POS [NUM_STICKY] = '{WAKE_BIT, INTR_BIT};

  logic [NUM_STICKY-1:0] stickyQ;
  logic [NUM_STICKY-1:0] stickySrc;
  logic                  statAct;
  logic                  intAct;

  assign stickySrc = {intPending, wakePresent};

  for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
    cstat_sticky_bit bit_i (
      .clk    (clk),
      .rstN   (rstN),
      .enable (strb.enable),
      .setReq (stickySrc[g]),
      .clrReq (strb.wrEvt & wrData[STICKY_POS[g]]),
      .q      (stickyQ[g])
    );
  end

  always_comb begin
    evtQ = '0;
    for (int i = 0; i < NUM_STICKY; i++) evtQ[STICKY_POS[i]] = stickyQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.wrMask) maskQ <= wrData & MASK_IMPL;
  end

  always_comb begin
    if (strb.rdEvt)       rdData = evtQ;
    else if (strb.rdMask) rdData = maskQ;
    else                  rdData = '0;
  end

  always_comb begin
    statAct  = strb.enable & maskQ[GWAKE_BIT] &
               (wpEvt | rdyEvt | battEvt | (maskQ[WAKE_BIT] & evtQ[WAKE_BIT]));
    intAct   = strb.enable & maskQ[INTR_BIT] & evtQ[INTR_BIT];
    statChgN = ~statAct;
    intN     = ~intAct;
  end
endmodule

// File: rtl/cstat_evt_top.sv
module cstat_evt_top
  import cstat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] EVT_OFS  = 'h24,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              wakePresent,
  input  logic              intPending,
  input  logic              wpEvt,
  input  logic              rdyEvt,
  input  logic              battEvt,
  output logic              statChgN,
  output logic              intN,
  output logic              pmeClr
);
  ctlStrb_t          strb;
  logic [DATA_W-1:0] evtQ;
  logic [DATA_W-1:0] maskQ;

  cstat_evt_ctrl #(.ADDR_W(ADDR_W), .EVT_OFS(EVT_OFS), .MASK_OFS(MASK_OFS)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .modeEn    (modeEn),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrWakeBit (wrData[WAKE_BIT]),
    .strb      (strb),
    .pmeClr    (pmeClr)
  );

  cstat_evt_dp dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .wakePresent (wakePresent),
    .intPending  (intPending),
    .wpEvt       (wpEvt),
    .rdyEvt      (rdyEvt),
    .battEvt     (battEvt),
    .rdData      (rdData),
    .evtQ        (evtQ),
    .maskQ       (maskQ),
    .statChgN    (statChgN),
    .intN        (intN)
  );
endmodule

// File: rtl/cstat_evt_chk.sv
module cstat_evt_chk
  import cstat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] EVT_OFS  = 'h24,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h28
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic              wakePresent,
  input logic              intPending,
  input logic              statChgN,
  input logic              intN,
  input logic              pmeClr,
  input logic [DATA_W-1:0] evtQ,
  input logic [DATA_W-1:0] maskQ
);
  a_r3_wake_sets: assert property (@(posedge clk) disable iff (!rstN)
    modeEn && wakePresent |=> evtQ[WAKE_BIT]);

  a_r5_intr_sets: assert property (@(posedge clk) disable iff (!rstN)
    modeEn && intPending |=> evtQ[INTR_BIT]);

  a_r4_pme_cause: assert property (@(posedge clk) disable iff (!rstN)
    pmeClr |-> $past(modeEn && wrEn && addr == EVT_OFS && wrData[WAKE_BIT]));

  a_r6_intn_gated: assert property (@(posedge clk) disable iff (!rstN)
    !intN |-> modeEn && maskQ[INTR_BIT] && evtQ[INTR_BIT]);

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !modeEn |-> statChgN && intN && rdData == '0);

  a_r9_disabled_hold: assert property (@(posedge clk) disable iff (!rstN)
    !modeEn |=> $stable(evtQ) && $stable(maskQ) && !pmeClr);

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    addr != EVT_OFS && addr != MASK_OFS |-> rdData == '0);
endmodule

bind cstat_evt_top cstat_evt_chk #(.ADDR_W(ADDR_W), .EVT_OFS(EVT_OFS), .MASK_OFS(MASK_OFS)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .modeEn      (modeEn),
  .wrEn        (wrEn),
  .addr        (addr),
  .wrData      (wrData),
  .rdData      (rdData),
  .wakePresent (wakePresent),
  .intPending  (intPending),
  .statChgN    (statChgN),
  .intN        (intN),
  .pmeClr      (pmeClr),
  .evtQ        (evtQ),
  .maskQ       (maskQ)
);

// File: tb/cstat_evt_top_tb_top.sv
module cstat_evt_top_tb_top;
  localparam logic [7:0] EVT  = 8'h24;
  localparam logic [7:0] MSK  = 8'h28;
  localparam logic [7:0] SPARE = 8'h2C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeEn = 1'b1;
  logic wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic wakePresent = 1'b0, intPending = 1'b0;
  logic wpEvt = 1'b0, rdyEvt = 1'b0, battEvt = 1'b0;
  logic statChgN, intN, pmeClr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cstat_evt_top dut_i (
    .clk(clk), .rstN(rstN), .modeEn(modeEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .wakePresent(wakePresent),
    .intPending(intPending), .wpEvt(wpEvt), .rdyEvt(rdyEvt), .battEvt(battEvt),
    .statChgN(statChgN), .intN(intN), .pmeClr(pmeClr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    regRead(EVT, d); check("R1 event reset", d, 32'h0);
    regRead(MSK, d); check("R1 mask reset", d, 32'h0);
    check("R1 statChgN", {31'b0, statChgN}, 32'h1);
    check("R1 intN", {31'b0, intN}, 32'h1);
    check("R1 pmeClr", {31'b0, pmeClr}, 32'h0);
  endtask

  task automatic t_mask_map;
    logic [31:0] d;
    regWrite(MSK, 32'hFFFF_FFFF);
    regRead(MSK, d); check("R2/R8 mask writable bits only", d, 32'h0000_C010);
    regWrite(MSK, 32'h0000_4000);
    regRead(MSK, d); check("R2 mask readback", d, 32'h0000_4000);
    regWrite(MSK, 32'h0);
    regWrite(SPARE, 32'hFFFF_FFFF);
    regRead(SPARE, d); check("R2 unmapped read", d, 32'h0);
    regRead(MSK, d); check("R2 unmapped write ignored", d, 32'h0);
    regRead(EVT, d); check("R8 event reserved after all-ones spare write", d, 32'h0);
  endtask

  task automatic t_wake;
    logic [31:0] d;
    wakePresent = 1'b1;
    idle(1);
    regRead(EVT, d); check("R3 wake sets", d, 32'h10);
    regWrite(EVT, 32'h10);
    check("R4 pmeClr pulse while source high", {31'b0, pmeClr}, 32'h1);
    regRead(EVT, d); check("R3 set wins over clear", d, 32'h10);
    idle(1);
    check("R4 pmeClr one cycle", {31'b0, pmeClr}, 32'h0);
    wakePresent = 1'b0;
    idle(2);
    regRead(EVT, d); check("R3 sticky after source drops", d, 32'h10);
    regWrite(EVT, 32'h0);
    regRead(EVT, d); check("R4 write 0 no effect", d, 32'h10);
    check("R4 no pmeClr on write 0", {31'b0, pmeClr}, 32'h0);
    regWrite(EVT, 32'hFFFF_FFFF);
    regRead(EVT, d); check("R4 write 1 clears", d, 32'h0);
    check("R4 pmeClr after clear", {31'b0, pmeClr}, 32'h1);
    idle(1);
    check("R4 pmeClr drops", {31'b0, pmeClr}, 32'h0);
  endtask

  task automatic t_intr;
    logic [31:0] d;
    intPending = 1'b1;
    idle(1);
    intPending = 1'b0;
    regRead(EVT, d); check("R5 intr sets with mask off", d, 32'h8000);
    check("R6 intN high with mask off", {31'b0, intN}, 32'h1);
    regWrite(MSK, 32'h8000);
    #1 check("R6 intN low when masked in", {31'b0, intN}, 32'h0);
    regWrite(EVT, 32'h8000);
    regRead(EVT, d); check("R5 intr cleared", d, 32'h0);
    check("R6 intN released", {31'b0, intN}, 32'h1);
    regWrite(MSK, 32'h0);
  endtask

  task automatic t_status;
    wpEvt = 1'b1;
    #1 check("R7 wp blocked without global enable", {31'b0, statChgN}, 32'h1);
    regWrite(MSK, 32'h4000);
    #1 check("R7 wp asserts", {31'b0, statChgN}, 32'h0);
    wpEvt = 1'b0; rdyEvt = 1'b1;
    #1 check("R7 ready asserts", {31'b0, statChgN}, 32'h0);
    rdyEvt = 1'b0; battEvt = 1'b1;
    #1 check("R7 battery asserts", {31'b0, statChgN}, 32'h0);
    battEvt = 1'b0;
    #1 check("R7 all quiet", {31'b0, statChgN}, 32'h1);
    idle(1);
    wakePresent = 1'b1; idle(1); wakePresent = 1'b0;
    #1 check("R7 wake needs its own enable", {31'b0, statChgN}, 32'h1);
    regWrite(MSK, 32'h4010);
    #1 check("R7 wake asserts with both enables", {31'b0, statChgN}, 32'h0);
    regWrite(MSK, 32'h0010);
    #1 check("R7 wake blocked without global", {31'b0, statChgN}, 32'h1);
    regWrite(EVT, 32'h10);
    regWrite(MSK, 32'h0);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    regWrite(MSK, 32'hC010);
    intPending = 1'b1; idle(1); intPending = 1'b0;
    #1 check("R6 intN low before disable", {31'b0, intN}, 32'h0);
    modeEn = 1'b0;
    wpEvt = 1'b1;
    regRead(EVT, d); check("R9 event reads 0", d, 32'h0);
    regRead(MSK, d); check("R9 mask reads 0", d, 32'h0);
    check("R9 intN high", {31'b0, intN}, 32'h1);
    check("R9 statChgN high", {31'b0, statChgN}, 32'h1);
    regWrite(EVT, 32'hFFFF_FFFF);
    check("R9 no pmeClr", {31'b0, pmeClr}, 32'h0);
    regWrite(MSK, 32'h0);
    wakePresent = 1'b1; idle(2); wakePresent = 1'b0;
    wpEvt = 1'b0;
    modeEn = 1'b1;
    regRead(EVT, d); check("R9 event kept, source not latched", d, 32'h8000);
    regRead(MSK, d); check("R9 mask kept", d, 32'h0000_C010);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    t_reset();
    t_mask_map();
    t_wake();
    t_intr();
    t_status();
    t_disable();
    idle(2);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule